// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block holds the register side of exception handling for a small processor core. When the core raises an exception it presents an exception code with its current program counter and machine state word. In one clock edge the unit fills the save registers, forms the handler address from a computed vector table combined with a prefix, and forms the handler state word. When the handler finishes, a return request reloads the program counter and state word from the saved pair, or from the critical save pair for critical returns. The unit strips the bits that must not travel across the boundary.

Exception code 2 is the machine-check class. If a machine check arrives while the machine-check-enable bit (bit 12 of the state word) is clear, the unit does not vector. It enters a sticky halted state instead, which only reset leaves. The vector for code `c` is `c * VEC_STRIDE`, which defaults to `c * 0x100`. A code listed as undefined has an all-ones table entry. Such an exception is refused with an error pulse.

Top module: `exc_unit`

## Requirements
- R1: On a taken exception, save register 1 receives the current state word with the bits of 0x783F0000 forced to zero.
- R2: On a taken exception, the handler state word is zero except bit 12, which is copied from the current state word; for code 2 (machine check) bit 12 is also zero.
- R3: On a taken exception, save register 0 receives PC-4 for the faulting codes {3,4,6,7} and PC for every other code.
- R4: On a taken exception, the new PC is (code * 0x100) bitwise-ORed with the prefix input.
- R5: Codes 0 and 15 are undefined. Such a request pulses vec_err together with done and changes no save register, no PC and no state word.
- R6: Codes {1,2,9} also copy the saved pair into the critical pair. Other codes leave the critical pair unchanged.
- R7: A normal return (ret_crit=0) loads PC from save register 0 with bits 1:0 cleared, and the state word from save register 1 with the bits of 0x783F0000 cleared.
- R8: A critical return (ret_crit=1) loads PC from critical register 0 with bits 1:0 cleared, and the state word from critical register 1 with the bits of 0x3FFF0000 cleared.
- R9: done is high exactly in the cycle after an accepted request and low otherwise.
- R10: A machine check with bit 12 of the current state word clear sets checkstop and changes no register. Once set, checkstop stays high until reset, and every later request is ignored with no done.
- R11: When an exception and a return are requested in the same cycle, the exception is taken and the return is dropped.
- R12: After reset all save registers, PC and state word outputs are zero, and done, vec_err and checkstop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_valid | input | 1 | Exception request strobe |
| exc_code | input | CODE_W | Exception code |
| cur_pc | input | XLEN | Next-instruction address of the core |
| cur_msr | input | XLEN | Current machine state word |
| vec_prefix | input | XLEN | Prefix ORed into handler address |
| ret_valid | input | 1 | Return request strobe |
| ret_crit | input | 1 | Return uses the critical pair |
| done | output | 1 | Request completed pulse |
| vec_err | output | 1 | Undefined vector pulse |
| checkstop | output | 1 | Sticky halted state |
| pc_out | output | XLEN | New program counter |
| msr_out | output | XLEN | New machine state word |
| save0 | output | XLEN | Save register 0 |
| save1 | output | XLEN | Save register 1 |
| csave0 | output | XLEN | Critical save register 0 |
| csave1 | output | XLEN | Critical save register 1 |

## Verification
The hardest condition to reach is the checkstop. It needs a machine-check code together with a clear enable bit. Once reached it is irreversible, and it masks all later checking of the normal paths. Random stimulus therefore forces the enable bit high on every machine check. The halt is entered only by a directed sequence at the end of the run, which then offers exceptions and returns and confirms that every register is unchanged and no done appears. Simultaneous exception and return requests, and critical returns after the critical pair was loaded, are mixed into the random stream.

// File: rtl/exc_pkg.sv
// Shared constants and types for the exception entry/return unit.
// Assumes a 32-bit state word; the masks below are sized to that.
package exc_pkg;
    localparam logic [31:0] SAVE_CLR_MASK = 32'h783F_0000;
    localparam logic [31:0] CRIT_CLR_MASK = 32'h3FFF_0000;
    localparam int          ME_BIT        = 12;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ENTRY,
        OP_VERR,
        OP_HALT,
        OP_RET_STD,
        OP_RET_CRIT
    } exc_op_e;
endpackage

// File: rtl/exc_vector_gen.sv
// Forms the handler address from a computed vector table and the prefix.
// Also looks up the per-code attributes. Assumes 2**CODE_W codes, each with
// a table entry of code*VEC_STRIDE, or all ones when the code is undefined.
module exc_vector_gen #(
    parameter int XLEN = 32,
    parameter int CODE_W = 4,
    parameter int VEC_STRIDE = 256,
    parameter logic [(1<<CODE_W)-1:0] UNDEF_SET = 16'h8001,
    parameter logic [(1<<CODE_W)-1:0] FAULT_SET = 16'h00D8,
    parameter logic [(1<<CODE_W)-1:0] CRIT_SET  = 16'h0206
) (
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   prefix,
    output logic [XLEN-1:0]   vec_addr,
    output logic              undefined,
    output logic              fault_attr,
    output logic              crit_attr
);
    localparam int NCODES = 1 << CODE_W;

    logic [XLEN-1:0] vec_tab [NCODES];

    // One table entry per code, all ones marks no handler
    for (genvar i = 0; i < NCODES; i++) begin : g_tab
        if (UNDEF_SET[i]) begin : g_undef
            assign vec_tab[i] = '1;
        end else begin : g_def
            assign vec_tab[i] = XLEN'(i * VEC_STRIDE);
        end
    end

    // Select entry and attributes for the presented code
    always_comb begin
        undefined  = (vec_tab[code] == '1);
        vec_addr   = vec_tab[code] | prefix;
        fault_attr = FAULT_SET[code];
        crit_attr  = CRIT_SET[code];
    end
endmodule

// File: rtl/exc_save_pair.sv
// One pair of save registers (address and state word). Loads both on wr_en.
// Assumes a synchronous active-low reset that clears both to zero.
module exc_save_pair #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [XLEN-1:0] d_addr,
    input  logic [XLEN-1:0] d_state,
    output logic [XLEN-1:0] q_addr,
    output logic [XLEN-1:0] q_state
);
    // Hold the pair, load it when the entry path writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_addr  <= '0;
            q_state <= '0;
        end else if (wr_en) begin
            q_addr  <= d_addr;
            q_state <= d_state;
        end
    end
endmodule

// File: rtl/exc_ctrl.sv
// Decides what a request does and registers the new PC, state word and
// status pulses. Assumes the vector lookup and the save pairs are outside.
// The exception request outranks a return in the same cycle.
module exc_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int CODE_W = 4,
    parameter int MCHK_CODE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_msr,
    input  logic              ret_valid,
    input  logic              ret_crit,
    input  logic [XLEN-1:0]   vec_addr,
    input  logic              vec_undef,
    input  logic              fault_attr,
    input  logic              crit_attr,
    input  logic [XLEN-1:0]   sv_addr,
    input  logic [XLEN-1:0]   sv_state,
    input  logic [XLEN-1:0]   cs_addr,
    input  logic [XLEN-1:0]   cs_state,
    output logic              pri_wr,
    output logic              crit_wr,
    output logic [XLEN-1:0]   wr_addr,
    output logic [XLEN-1:0]   wr_state,
    output logic              done,
    output logic              vec_err,
    output logic              checkstop,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   msr_out
);
    localparam logic [XLEN-1:0] ME_MASK   = XLEN'(1) << ME_BIT;
    localparam logic [XLEN-1:0] SAVE_CLR  = XLEN'(SAVE_CLR_MASK);
    localparam logic [XLEN-1:0] CRIT_CLR  = XLEN'(CRIT_CLR_MASK);
    localparam logic [XLEN-1:0] ALIGN_CLR = XLEN'(3);

    exc_op_e         op;
    logic            is_mchk;
    logic [XLEN-1:0] nxt_pc;
    logic [XLEN-1:0] nxt_msr;

    // Classify the request of this cycle
    always_comb begin
        is_mchk = (exc_code == CODE_W'(MCHK_CODE));
        op      = OP_IDLE;
        if (!checkstop) begin
            if (exc_valid) begin
                if (is_mchk && !cur_msr[ME_BIT]) op = OP_HALT;
                else if (vec_undef)              op = OP_VERR;
                else                             op = OP_ENTRY;
            end else if (ret_valid) begin
                op = ret_crit ? OP_RET_CRIT : OP_RET_STD;
            end
        end
    end

    // Values written into the save registers on entry
    always_comb begin
        wr_addr  = fault_attr ? (cur_pc - XLEN'(4)) : cur_pc;
        wr_state = cur_msr & ~SAVE_CLR;
        pri_wr   = (op == OP_ENTRY);
        crit_wr  = (op == OP_ENTRY) && crit_attr;
    end

    // Next PC and state word for entry or return
    always_comb begin
        nxt_pc  = pc_out;
        nxt_msr = msr_out;
        case (op)
            OP_ENTRY: begin
                nxt_pc  = vec_addr;
                nxt_msr = is_mchk ? '0 : (cur_msr & ME_MASK);
            end
            OP_RET_STD: begin
                nxt_pc  = sv_addr & ~ALIGN_CLR;
                nxt_msr = sv_state & ~SAVE_CLR;
            end
            OP_RET_CRIT: begin
                nxt_pc  = cs_addr & ~ALIGN_CLR;
                nxt_msr = cs_state & ~CRIT_CLR;
            end
            default: ;
        endcase
    end

    // Register outputs and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_out    <= '0;
            msr_out   <= '0;
            done      <= 1'b0;
            vec_err   <= 1'b0;
            checkstop <= 1'b0;
        end else begin
            pc_out  <= nxt_pc;
            msr_out <= nxt_msr;
            done    <= (op != OP_IDLE);
            vec_err <= (op == OP_VERR);
            if (op == OP_HALT) checkstop <= 1'b1;
        end
    end

    // R9
    done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_valid || ret_valid) && !checkstop) |=> done);
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exc_valid || ret_valid) || checkstop) |=> !done);
    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop |=> checkstop);
    // R2
    handler_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ENTRY) |=> ($countones(msr_out) <= 1 && (msr_out & ~ME_MASK) == '0));
    // R7
    ret_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET_STD || op == OP_RET_CRIT) |=> (pc_out[1:0] == 2'b00));
endmodule

// File: rtl/exc_unit.sv
// Top of the exception entry/return unit. Wires the vector lookup, the
// control path and two save pairs (index 0 primary, index 1 critical).
// Assumes one request per cycle at most per strobe; exception wins a tie.
module exc_unit #(
    parameter int XLEN = 32,
    parameter int CODE_W = 4,
    parameter int VEC_STRIDE = 256,
    parameter int MCHK_CODE = 2,
    parameter logic [(1<<CODE_W)-1:0] UNDEF_SET = 16'h8001,
    parameter logic [(1<<CODE_W)-1:0] FAULT_SET = 16'h00D8,
    parameter logic [(1<<CODE_W)-1:0] CRIT_SET  = 16'h0206
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   cur_msr,
    input  logic [XLEN-1:0]   vec_prefix,
    input  logic              ret_valid,
    input  logic              ret_crit,
    output logic              done,
    output logic              vec_err,
    output logic              checkstop,
    output logic [XLEN-1:0]   pc_out,
    output logic [XLEN-1:0]   msr_out,
    output logic [XLEN-1:0]   save0,
    output logic [XLEN-1:0]   save1,
    output logic [XLEN-1:0]   csave0,
    output logic [XLEN-1:0]   csave1
);
    localparam int NPAIRS = 2;

    logic [XLEN-1:0] vec_addr;
    logic            vec_undef;
    logic            fault_attr;
    logic            crit_attr;
    logic            pri_wr;
    logic            crit_wr;
    logic [XLEN-1:0] wr_addr;
    logic [XLEN-1:0] wr_state;
    logic [NPAIRS-1:0] pair_wr;
    logic [XLEN-1:0] pair_addr  [NPAIRS];
    logic [XLEN-1:0] pair_state [NPAIRS];

    exc_vector_gen #(
        .XLEN(XLEN), .CODE_W(CODE_W), .VEC_STRIDE(VEC_STRIDE),
        .UNDEF_SET(UNDEF_SET), .FAULT_SET(FAULT_SET), .CRIT_SET(CRIT_SET)
    ) u_vec (
        .code(exc_code), .prefix(vec_prefix), .vec_addr(vec_addr),
        .undefined(vec_undef), .fault_attr(fault_attr), .crit_attr(crit_attr)
    );

    exc_ctrl #(.XLEN(XLEN), .CODE_W(CODE_W), .MCHK_CODE(MCHK_CODE)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .exc_valid(exc_valid), .exc_code(exc_code),
        .cur_pc(cur_pc), .cur_msr(cur_msr),
        .ret_valid(ret_valid), .ret_crit(ret_crit),
        .vec_addr(vec_addr), .vec_undef(vec_undef),
        .fault_attr(fault_attr), .crit_attr(crit_attr),
        .sv_addr(pair_addr[0]), .sv_state(pair_state[0]),
        .cs_addr(pair_addr[1]), .cs_state(pair_state[1]),
        .pri_wr(pri_wr), .crit_wr(crit_wr),
        .wr_addr(wr_addr), .wr_state(wr_state),
        .done(done), .vec_err(vec_err), .checkstop(checkstop),
        .pc_out(pc_out), .msr_out(msr_out)
    );

    assign pair_wr = {crit_wr, pri_wr};

    // Primary and critical pairs share data, differ in write enable
    for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
        exc_save_pair #(.XLEN(XLEN)) u_pair (
            .clk(clk), .rst_n(rst_n), .wr_en(pair_wr[p]),
            .d_addr(wr_addr), .d_state(wr_state),
            .q_addr(pair_addr[p]), .q_state(pair_state[p])
        );
    end

    assign save0  = pair_addr[0];
    assign save1  = pair_state[0];
    assign csave0 = pair_addr[1];
    assign csave1 = pair_state[1];

    // R5
    undef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_err |-> ($stable(save0) && $stable(save1) && $stable(pc_out)));
    // R10
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(checkstop) |-> ($stable(save0) && $stable(csave0) && !done));
    // R6
    crit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_wr && !crit_wr) |=> ($stable(csave0) && $stable(csave1)));
    // R1
    save_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pri_wr |=> ((save1 & 32'h783F_0000) == '0));
endmodule

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [3:0]  exc_code = '0;
    logic [31:0] cur_pc = '0, cur_msr = '0, vec_prefix = '0;
    logic        ret_valid = 1'b0, ret_crit = 1'b0;
    logic        done, vec_err, checkstop;
    logic [31:0] pc_out, msr_out, save0, save1, csave0, csave1;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    logic [31:0] m_s0 = 0, m_s1 = 0, m_c0 = 0, m_c1 = 0, m_pc = 0, m_msr = 0;
    bit m_halt = 0;

    exc_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_undef(input logic [3:0] c);
        return (c == 4'd0 || c == 4'd15);
    endfunction
    function automatic bit is_fault(input logic [3:0] c);
        return (c == 4'd3 || c == 4'd4 || c == 4'd6 || c == 4'd7);
    endfunction
    function automatic bit is_crit(input logic [3:0] c);
        return (c == 4'd1 || c == 4'd2 || c == 4'd9);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one request for a cycle, update model, check outputs after the edge
    task automatic op(input bit e, input logic [3:0] c, input logic [31:0] pc,
                      input logic [31:0] msr, input logic [31:0] pf,
                      input bit r, input bit rc);
        bit exp_done, exp_verr;
        exp_done = 0; exp_verr = 0;
        if (!m_halt) begin
            if (e) begin
                exp_done = 1;
                if (c == 4'd2 && !msr[12]) begin
                    m_halt = 1;
                end else if (is_undef(c)) begin
                    exp_verr = 1;
                end else begin
                    m_s0 = is_fault(c) ? pc - 32'd4 : pc;
                    m_s1 = msr & ~32'h783F_0000;
                    if (is_crit(c)) begin m_c0 = m_s0; m_c1 = m_s1; end
                    m_pc = ({28'd0, c} << 8) | pf;
                    m_msr = (c == 4'd2) ? 32'd0 : (msr & 32'h0000_1000);
                end
            end else if (r) begin
                exp_done = 1;
                if (rc) begin
                    m_pc = m_c0 & ~32'd3; m_msr = m_c1 & ~32'h3FFF_0000;
                end else begin
                    m_pc = m_s0 & ~32'd3; m_msr = m_s1 & ~32'h783F_0000;
                end
            end
        end
        exc_valid = e; exc_code = c; cur_pc = pc; cur_msr = msr;
        vec_prefix = pf; ret_valid = r; ret_crit = rc;
        @(negedge clk);
        exc_valid = 0; ret_valid = 0;
        chk("R9", "done", 32'(done), 32'(exp_done));
        chk("R5", "vec_err", 32'(vec_err), 32'(exp_verr));
        chk("R10", "checkstop", 32'(checkstop), 32'(m_halt));
        chk("R3", "save0", save0, m_s0);
        chk("R1", "save1", save1, m_s1);
        chk("R6", "csave0", csave0, m_c0);
        chk("R6", "csave1", csave1, m_c1);
        chk(r && !e ? (rc ? "R8" : "R7") : "R4", "pc_out", pc_out, m_pc);
        chk(r && !e ? (rc ? "R8" : "R7") : "R2", "msr_out", msr_out, m_msr);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++; fails++;
            $display("FAIL R9 watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12", "pc_out", pc_out, 0);
        chk("R12", "msr_out", msr_out, 0);
        chk("R12", "save0", save0, 0);
        chk("R12", "csave1", csave1, 0);
        chk("R12", "flags", {29'd0, done, vec_err, checkstop}, 0);

        // Directed: machine check with enable set, critical copy, then returns
        op(1, 4'd2, 32'h0000_2000, 32'hFFFF_FFFF, 32'h0, 0, 0);
        op(0, 4'd0, 0, 0, 0, 1, 1);      // R8 critical return
        op(1, 4'd3, 32'h0000_1002, 32'h8000_1003, 32'hFFF0_0000, 0, 0);
        op(0, 4'd0, 0, 0, 0, 1, 0);      // R7 normal return, low bits cleared
        op(1, 4'd15, 32'h1234_5678, 32'h1, 32'h0, 0, 0);  // R5 undefined
        op(1, 4'd0, 32'h1234_5678, 32'h1, 32'h0, 0, 0);   // R5 undefined
        op(1, 4'd5, 32'h0000_4000, 32'h0000_1000, 32'h0, 1, 1); // R11 tie
        op(0, 4'd0, 0, 0, 0, 0, 0);      // R9 idle gives no done

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0]  c;
            logic [31:0] m;
            bit e, r;
            c = 4'($urandom_range(0, 15));
            m = $urandom;
            if (c == 4'd2) m[12] = 1'b1;
            e = ($urandom_range(0, 2) != 0);
            r = ($urandom_range(0, 2) == 0);
            op(e, c, $urandom, m, $urandom & 32'hFFFF_F000, r, 1'($urandom));
        end

        // R10 checkstop entry and lockout
        op(1, 4'd2, 32'h0000_0100, 32'h0000_0000, 32'h0, 0, 0);
        op(1, 4'd4, 32'h0000_0200, 32'h0000_1000, 32'h0, 0, 0);
        op(0, 4'd0, 0, 0, 0, 1, 0);
        op(1, 4'd9, 32'h0000_0300, 32'h0000_1000, 32'h0, 1, 1);
        finish_run();
    end
endmodule